// File: doc/BRIEF.md
# Sleep Mode Clock-Gating Controller

This block holds the sleep state machine of a small microcontroller core. While the core runs, a one-cycle sleep strobe, accepted only when the sleep-enable input is high, takes the block into one of three sleep states. The 3-bit mode select picks the state. Each state drives its own pattern of enables for the CPU, flash, I/O and timer clock domains, and for the fast RC oscillator, the external clock input, the voltage monitor and the brown-out detector.

Every sleep state accepts its own set of wake-up requests. The light idle state and the timer-only quiet state return to running on the edge that samples a legal request. The deep power-down state first passes through a warm-up state. There the oscillators restart, and the clock domains stay gated until a start-up delay has been counted on ticks of an always-running slow reference clock. A two-bit setting selects the length of that delay. A one-cycle wake pulse marks every return to running.

States: `ST_RUN` (running), `ST_IDLE` (CPU clock gated), `ST_QUIET` (CPU, flash and I/O clocks gated; timers run), `ST_DEEP` (power-down), `ST_WARM` (start-up delay after power-down). Transitions:
- `enter_idle` (RUN to IDLE)
- `enter_quiet` (RUN to QUIET)
- `enter_deep` (RUN to DEEP)
- `idle_wake` (IDLE to RUN)
- `quiet_wake` (QUIET to RUN)
- `deep_wake` (DEEP to WARM)
- `warm_done` (WARM to RUN)
- `reset` (any state to RUN)

Top module: `slp_clkgate_ctrl`

## Requirements
- R1: With `sleep_en` high in running state, a `sleep_req` strobe enters quiet for `mode_sel`=001, deep for 010, and idle for every other code; the enables change after that same edge.
- R2: A `sleep_req` strobe while `sleep_en` is low is ignored: all clock enables stay high.
- R3: In idle, `clk_cpu_en` is 0 and every other enable is 1.
- R4: In quiet, the CPU, flash and I/O enables are 0, and the timer, oscillator, external clock, voltage monitor and brown-out enables are 1.
- R5: Quiet is left only for a timer event, and only when bit i of `tmr_evt` coincides with bit i of `tmr_ie` and `gie` is high; no other request wakes it.
- R6: In deep, every enable is 0 except `bod_en`, which equals `bod_keep`.
- R7: Deep is left for a pin-change, receiver start, watchdog reset or external reset request, or for bit i of `ext_irq` while `ext_lvl[i]`=1 (level configured); edge-configured external requests (`ext_lvl[i]`=0) and timer events are ignored.
- R8: After a deep wake, the warm-up state keeps the domain clocks gated with `frc_en` and `xclk_en` high. It counts `ref_tick` cycles up to N (`sut_sel` 00: 4, 01: 64, 10: 512, 11: 4096). With `ref_tick` held high, `clk_cpu_en` returns on the edge N+1 edges after the one that samples the wake. Cycles without `ref_tick` are not counted.
- R9: Idle and quiet return to running on the edge that samples a legal request, with no delay; idle accepts every request input, including `misc_irq`.
- R10: `wake_pulse` is high for exactly one cycle, the first running cycle after any exit from sleep.
- R11: An asserted `rst_n` low forces running state at once, from any state, with all enables high and `wake_pulse` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | One-cycle sleep instruction strobe |
| sleep_en | input | 1 | Sleep strobe qualifier |
| mode_sel | input | 3 | Sleep mode select |
| sut_sel | input | 2 | Start-up delay setting |
| bod_keep | input | 1 | Keep brown-out detector alive in deep |
| ref_tick | input | 1 | Tick of the always-running slow reference clock |
| tmr_evt | input | 6 | Overflow, capture and compare events of two timers |
| tmr_ie | input | 6 | Per-event timer interrupt enables |
| gie | input | 1 | Global interrupt enable |
| ext_irq | input | 2 | External interrupt requests |
| ext_lvl | input | 2 | 1 = external interrupt is level configured |
| pcint_req | input | 1 | Pin-change interrupt request |
| rxstart_req | input | 1 | Receiver start-condition interrupt request |
| wdt_rst_req | input | 1 | Watchdog reset request |
| xrst_req | input | 1 | External reset request |
| misc_irq | input | 1 | Any other qualified interrupt request |
| clk_cpu_en | output | 1 | CPU clock enable |
| clk_flash_en | output | 1 | Flash clock enable |
| clk_io_en | output | 1 | I/O clock enable |
| clk_tmr_en | output | 1 | Timer clock domain enable |
| frc_en | output | 1 | Fast RC oscillator enable |
| xclk_en | output | 1 | External clock input enable |
| vmon_en | output | 1 | Voltage monitor enable |
| bod_en | output | 1 | Brown-out detector enable |
| wake_pulse | output | 1 | One-cycle return-to-running marker |

## Verification
The embedded properties watch several things on every cycle: entry into sleep after an accepted strobe, the refusal of a strobe without sleep-enable, deep staying put without a legal request, the immediate quiet exit, the one-cycle shape of the wake pulse, and the bound on the warm-up count. The scenarios alone show the exact enable pattern of each mode, the mapping of unassigned mode codes to idle, and the qualification of timer events by their enables. They also show the exact warm-up length for each of the four settings, the pause while reference ticks are absent, and the asynchronous return on reset.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_QUIET = 3'd2,
        ST_DEEP  = 3'd3,
        ST_WARM  = 3'd4
    } slp_state_e;

    localparam logic [2:0] MODE_QUIET = 3'b001;
    localparam logic [2:0] MODE_DEEP  = 3'b010;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
        logic tmr;
        logic frc;
        logic xclk;
        logic vmon;
        logic bod;
    } clk_en_t;

endpackage

// File: rtl/slp_wake_qual.sv
module slp_wake_qual #(
    parameter int N_TEVT = 6,
    parameter int N_EXT  = 2
) (
    input  logic [N_TEVT-1:0] tmr_evt,
    input  logic [N_TEVT-1:0] tmr_ie,
    input  logic              gie,
    input  logic [N_EXT-1:0]  ext_irq,
    input  logic [N_EXT-1:0]  ext_lvl,
    input  logic              pcint_req,
    input  logic              rxstart_req,
    input  logic              wdt_rst_req,
    input  logic              xrst_req,
    input  logic              misc_irq,
    output logic              wake_idle,
    output logic              wake_quiet,
    output logic              wake_deep
);

    logic [N_EXT-1:0] ext_level_hit;
    logic             tmr_hit;
    logic             reset_hit;

    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        assign ext_level_hit[g] = ext_irq[g] & ext_lvl[g];
    end

    assign tmr_hit   = gie & (|(tmr_evt & tmr_ie));
    assign reset_hit = wdt_rst_req | xrst_req;

    assign wake_quiet = tmr_hit;
    assign wake_deep  = (|ext_level_hit) | pcint_req | rxstart_req | reset_hit;
    assign wake_idle  = tmr_hit | (|ext_irq) | pcint_req | rxstart_req
                      | reset_hit | misc_irq;

endmodule

// File: rtl/slp_stup_timer.sv
module slp_stup_timer #(
    parameter int DLY_SUT0 = 4,
    parameter int DLY_SUT1 = 64,
    parameter int DLY_SUT2 = 512,
    parameter int DLY_SUT3 = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       run,
    input  logic       tick,
    input  logic [1:0] sel,
    output logic       done
);

    localparam int CNT_W = $clog2(DLY_SUT3 + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] target;
    logic [1:0]       sel_q;

    always_comb begin
        unique case (sel_q)
            2'd0:    target = CNT_W'(DLY_SUT0);
            2'd1:    target = CNT_W'(DLY_SUT1);
            2'd2:    target = CNT_W'(DLY_SUT2);
            default: target = CNT_W'(DLY_SUT3);
        endcase
    end

    assign done = (cnt == target);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            sel_q <= 2'd0;
        end else if (start) begin
            cnt   <= '0;
            sel_q <= sel;
        end else if (run && tick && !done) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= target)); // R8

endmodule

// File: rtl/slp_clkgate_ctrl.sv
module slp_clkgate_ctrl
    import slp_pkg::*;
#(
    parameter int N_TEVT   = 6,
    parameter int N_EXT    = 2,
    parameter int DLY_SUT0 = 4,
    parameter int DLY_SUT1 = 64,
    parameter int DLY_SUT2 = 512,
    parameter int DLY_SUT3 = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic              sleep_en,
    input  logic [2:0]        mode_sel,
    input  logic [1:0]        sut_sel,
    input  logic              bod_keep,
    input  logic              ref_tick,
    input  logic [N_TEVT-1:0] tmr_evt,
    input  logic [N_TEVT-1:0] tmr_ie,
    input  logic              gie,
    input  logic [N_EXT-1:0]  ext_irq,
    input  logic [N_EXT-1:0]  ext_lvl,
    input  logic              pcint_req,
    input  logic              rxstart_req,
    input  logic              wdt_rst_req,
    input  logic              xrst_req,
    input  logic              misc_irq,
    output logic              clk_cpu_en,
    output logic              clk_flash_en,
    output logic              clk_io_en,
    output logic              clk_tmr_en,
    output logic              frc_en,
    output logic              xclk_en,
    output logic              vmon_en,
    output logic              bod_en,
    output logic              wake_pulse
);

    slp_state_e state, state_nx;
    clk_en_t    en;
    logic       wake_idle, wake_quiet, wake_deep;
    logic       warm_done;
    logic       deep_wake;
    logic       sleep_go;

    slp_wake_qual #(.N_TEVT(N_TEVT), .N_EXT(N_EXT)) u_qual (
        .tmr_evt     (tmr_evt),
        .tmr_ie      (tmr_ie),
        .gie         (gie),
        .ext_irq     (ext_irq),
        .ext_lvl     (ext_lvl),
        .pcint_req   (pcint_req),
        .rxstart_req (rxstart_req),
        .wdt_rst_req (wdt_rst_req),
        .xrst_req    (xrst_req),
        .misc_irq    (misc_irq),
        .wake_idle   (wake_idle),
        .wake_quiet  (wake_quiet),
        .wake_deep   (wake_deep)
    );

    assign deep_wake = (state == ST_DEEP) && wake_deep;

    slp_stup_timer #(
        .DLY_SUT0(DLY_SUT0), .DLY_SUT1(DLY_SUT1),
        .DLY_SUT2(DLY_SUT2), .DLY_SUT3(DLY_SUT3)
    ) u_stup (
        .clk   (clk),
        .rst_n (rst_n),
        .start (deep_wake),
        .run   (state == ST_WARM),
        .tick  (ref_tick),
        .sel   (sut_sel),
        .done  (warm_done)
    );

    assign sleep_go = sleep_req && sleep_en;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (sleep_go) begin
                    if (mode_sel == MODE_QUIET)     state_nx = ST_QUIET;
                    else if (mode_sel == MODE_DEEP) state_nx = ST_DEEP;
                    else                            state_nx = ST_IDLE;
                end
            end
            ST_IDLE:  if (wake_idle)  state_nx = ST_RUN;
            ST_QUIET: if (wake_quiet) state_nx = ST_RUN;
            ST_DEEP:  if (wake_deep)  state_nx = ST_WARM;
            ST_WARM:  if (warm_done)  state_nx = ST_RUN;
            default:  state_nx = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // wake marker register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake_pulse <= 1'b0;
        else        wake_pulse <= (state != ST_RUN) && (state_nx == ST_RUN);
    end

    // output decode
    always_comb begin
        en = '1;
        unique case (state)
            ST_RUN:   en = '1;
            ST_IDLE:  en.cpu = 1'b0;
            ST_QUIET: begin
                en.cpu   = 1'b0;
                en.flash = 1'b0;
                en.io    = 1'b0;
            end
            ST_DEEP: begin
                en     = '0;
                en.bod = bod_keep;
            end
            ST_WARM: begin
                en      = '0;
                en.frc  = 1'b1;
                en.xclk = 1'b1;
                en.bod  = bod_keep;
            end
            default:  en = '1;
        endcase
    end

    assign clk_cpu_en   = en.cpu;
    assign clk_flash_en = en.flash;
    assign clk_io_en    = en.io;
    assign clk_tmr_en   = en.tmr;
    assign frc_en       = en.frc;
    assign xclk_en      = en.xclk;
    assign vmon_en      = en.vmon;
    assign bod_en       = en.bod;

    AST_SLEEP_GATES_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_req && sleep_en) |=> !clk_cpu_en); // R1
    AST_NO_SLEEP_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !sleep_en) |=> clk_cpu_en); // R2
    AST_DEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEEP && !wake_deep) |=> (state == ST_DEEP && !clk_cpu_en)); // R7
    AST_QUIET_FAST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUIET && wake_quiet) |=> (clk_cpu_en && wake_pulse)); // R9
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse); // R10
    AST_PULSE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (clk_cpu_en && clk_flash_en && clk_io_en)); // R10

endmodule

// File: tb/test_slp_clkgate_ctrl.sv
module test_slp_clkgate_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0, sleep_en = 1'b0;
    logic [2:0] mode_sel = '0;
    logic [1:0] sut_sel = '0;
    logic       bod_keep = 1'b0, ref_tick = 1'b1;
    logic [5:0] tmr_evt = '0, tmr_ie = '0;
    logic       gie = 1'b0;
    logic [1:0] ext_irq = '0, ext_lvl = '0;
    logic       pcint_req = 1'b0, rxstart_req = 1'b0;
    logic       wdt_rst_req = 1'b0, xrst_req = 1'b0, misc_irq = 1'b0;
    logic       clk_cpu_en, clk_flash_en, clk_io_en, clk_tmr_en;
    logic       frc_en, xclk_en, vmon_en, bod_en, wake_pulse;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    slp_clkgate_ctrl i_slp_clkgate_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_en(sleep_en),
        .mode_sel(mode_sel), .sut_sel(sut_sel), .bod_keep(bod_keep),
        .ref_tick(ref_tick), .tmr_evt(tmr_evt), .tmr_ie(tmr_ie), .gie(gie),
        .ext_irq(ext_irq), .ext_lvl(ext_lvl), .pcint_req(pcint_req),
        .rxstart_req(rxstart_req), .wdt_rst_req(wdt_rst_req),
        .xrst_req(xrst_req), .misc_irq(misc_irq),
        .clk_cpu_en(clk_cpu_en), .clk_flash_en(clk_flash_en),
        .clk_io_en(clk_io_en), .clk_tmr_en(clk_tmr_en), .frc_en(frc_en),
        .xclk_en(xclk_en), .vmon_en(vmon_en), .bod_en(bod_en),
        .wake_pulse(wake_pulse)
    );

    // {cpu, flash, io, tmr, frc, xclk, vmon, bod}
    function automatic logic [7:0] ens();
        return {clk_cpu_en, clk_flash_en, clk_io_en, clk_tmr_en,
                frc_en, xclk_en, vmon_en, bod_en};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic go_sleep(input logic [2:0] m);
        sleep_en = 1'b1;
        mode_sel = m;
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    // wait for CPU clock to return, counting negedges from the drive point
    task automatic warm_count(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
            pcint_req = 1'b0;
        end while (!clk_cpu_en && k < 5000);
    endtask

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            default: return "R6";
        endcase
    endfunction

    // {req[3:0], sleep_en, mode[2:0], bod_keep, expected enables[7:0]}
    localparam logic [16:0] VEC [9] = '{
        {4'd3, 1'b1, 3'b000, 1'b0, 8'b0111_1111},
        {4'd4, 1'b1, 3'b001, 1'b0, 8'b0001_1111},
        {4'd6, 1'b1, 3'b010, 1'b0, 8'b0000_0000},
        {4'd6, 1'b1, 3'b010, 1'b1, 8'b0000_0001},
        {4'd1, 1'b1, 3'b011, 1'b0, 8'b0111_1111},
        {4'd1, 1'b1, 3'b111, 1'b0, 8'b0111_1111},
        {4'd1, 1'b1, 3'b100, 1'b1, 8'b0111_1111},
        {4'd2, 1'b0, 3'b010, 1'b0, 8'b1111_1111},
        {4'd2, 1'b0, 3'b001, 1'b0, 8'b1111_1111}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual 0 expected 1 (run finished)");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin : main
        int k;
        @(negedge clk);
        // R11: reset state
        check("R11 reset enables", int'(ens()), 8'hFF);
        check("R11 reset pulse", int'(wake_pulse), 0);
        do_reset();

        // table walk: mode entry and enable patterns
        for (int i = 0; i < 9; i++) begin
            bod_keep = VEC[i][8];
            sleep_en = VEC[i][12];
            mode_sel = VEC[i][11:9];
            sleep_req = 1'b1;
            @(negedge clk);
            sleep_req = 1'b0;
            check(req_name(VEC[i][16:13]), int'(ens()), int'(VEC[i][7:0]));
            do_reset();
        end
        bod_keep = 1'b0;

        // R5: quiet ignores timer event without gie, or with mismatched enable
        go_sleep(3'b001);
        tmr_evt = 6'b000100; tmr_ie = 6'b000100; gie = 1'b0;
        @(negedge clk);
        check("R5 no gie", int'(clk_cpu_en), 0);
        tmr_ie = 6'b001000; gie = 1'b1;
        @(negedge clk);
        check("R5 ie mismatch", int'(clk_cpu_en), 0);
        pcint_req = 1'b1; misc_irq = 1'b1; ext_irq = 2'b11; ext_lvl = 2'b11;
        @(negedge clk);
        check("R5 other requests ignored", int'(clk_cpu_en), 0);
        pcint_req = 1'b0; misc_irq = 1'b0; ext_irq = 2'b00; ext_lvl = 2'b00;
        tmr_ie = 6'b000100;
        @(negedge clk);
        check("R9 quiet immediate wake", int'(ens()), 8'hFF);
        check("R10 pulse high", int'(wake_pulse), 1);
        tmr_evt = '0; tmr_ie = '0; gie = 1'b0;
        @(negedge clk);
        check("R10 pulse one cycle", int'(wake_pulse), 0);

        // R9: idle woken by misc request
        go_sleep(3'b000);
        check("R3 idle gated", int'(clk_cpu_en), 0);
        misc_irq = 1'b1;
        @(negedge clk);
        misc_irq = 1'b0;
        check("R9 idle misc wake", int'(clk_cpu_en), 1);
        check("R10 idle pulse", int'(wake_pulse), 1);

        // R7: deep ignores edge-configured external and timer events
        go_sleep(3'b010);
        ext_irq = 2'b11; ext_lvl = 2'b00;
        tmr_evt = 6'h3F; tmr_ie = 6'h3F; gie = 1'b1; misc_irq = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 edge ext ignored", int'(ens()), 8'h00);
        tmr_evt = '0; tmr_ie = '0; gie = 1'b0; misc_irq = 1'b0;
        ext_lvl = 2'b10;
        @(negedge clk);
        ext_irq = 2'b00; ext_lvl = 2'b00;
        check("R8 warm enables", int'(ens()), 8'b0000_1100);
        begin
            k = 1;
            while (!clk_cpu_en && k < 5000) begin @(negedge clk); k++; end
        end
        check("R8 sut 00 length", k, 4 + 2);
        check("R10 deep pulse", int'(wake_pulse), 1);

        // R8: other start-up settings via pin-change wake
        for (int s = 1; s < 4; s++) begin
            sut_sel = 2'(s);
            go_sleep(3'b010);
            pcint_req = 1'b1;
            warm_count(k);
            check("R8 sut length", k, ((s == 1) ? 64 : (s == 2) ? 512 : 4096) + 2);
        end
        sut_sel = 2'b00;

        // R8: missing reference ticks pause the count
        go_sleep(3'b010);
        ref_tick = 1'b0;
        rxstart_req = 1'b1;
        @(negedge clk);
        rxstart_req = 1'b0;
        repeat (20) @(negedge clk);
        check("R8 paused without ticks", int'(clk_cpu_en), 0);
        ref_tick = 1'b1;
        warm_count(k);
        check("R8 resume after ticks", k, 5);

        // R7: watchdog reset request wakes deep
        go_sleep(3'b010);
        wdt_rst_req = 1'b1;
        @(negedge clk);
        wdt_rst_req = 1'b0;
        check("R7 watchdog wake", int'(frc_en), 1);
        repeat (10) @(negedge clk);

        // R11: asynchronous reset from deep
        go_sleep(3'b010);
        #1 rst_n = 1'b0;
        #1;
        check("R11 async reset", int'(ens()), 8'hFF);
        check("R11 no pulse", int'(wake_pulse), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule